// File: doc/BRIEF.md
# SPI Pause Controller

This block sits between the pins of an SPI slave and the slave's shift logic and adds a pause input. The serial clock, chip select, pause input and serial data all arrive from outside. Each one is brought into a faster system clock through a two-flop synchronizer, and its edges are detected in that domain. From these the block produces three things: a one-cycle shift strobe carrying the sampled data bit, a one-cycle strobe that tells the output shifter when to present its next bit, and an enable for the tri-state driver of the serial data output.

The pause input is active low. While the slave is selected, a pause freezes the transfer at the bit where it stopped. Serial clock and data activity is then ignored, and the bit position within the current word is kept. Both entering and leaving the pause depend on the level of the serial clock. A request made while the clock is high is held back until the next falling clock edge. A release made while the clock is high has no effect. Raising chip select still ends the transfer and clears any pause, so the next selection starts unpaused.

The internal state (running, pause deferred, paused) and a word-bit position counter drive the outputs. All outputs are registered. A pin change reaches the outputs three system clocks later: two synchronizer stages plus the output register.

Top module: `spi_pause_ctrl`

## Requirements
- R1: After reset the outputs are idle: out_en=0, paused=0, shift_en=0, out_upd=0, bit_pos=0.
- R2: While selected and not paused, every rising SCK edge gives exactly one shift_en pulse, with shift_bit equal to the SI level at that edge. bit_pos counts these pulses modulo WORD_BITS (default 8).
- R3: A falling SCK edge gives one out_upd pulse, but only while the block is selected, running (no pause active or deferred) and the pause input is high.
- R4: out_en is 1 only while chip select is low, the pause input is high and the block is not paused. It drops at the same time for a pause input falling with SCK low and for one falling with SCK high (a deferred pause).
- R5: Pulling the pause input low while SCK is low enters the pause at once (paused=1).
- R6: Pulling the pause input low while SCK is high leaves paused=0 until the next falling SCK edge. That edge enters the pause and produces no out_upd.
- R7: While paused, SCK and SI activity produces no shift_en, and bit_pos holds its value. After a release the word continues from that bit position.
- R8: A rising pause input while SCK is low resumes the transfer. A rise while SCK is high leaves the block paused, even after SCK later falls.
- R9: Chip select going high clears the pause, any deferred pause and bit_pos. The next selection starts unpaused.
- R10: If the pause input returns high before the falling SCK edge that would apply a deferred pause, the pause is cancelled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than SCK |
| rst | input | 1 | Synchronous active-high reset |
| sck_pin | input | 1 | Serial clock pin (asynchronous) |
| cs_n_pin | input | 1 | Chip select pin, active low (asynchronous) |
| hold_n_pin | input | 1 | Pause input pin, active low (asynchronous) |
| si_pin | input | 1 | Serial data input pin (asynchronous) |
| shift_en | output | 1 | One-cycle strobe: shift in shift_bit |
| shift_bit | output | 1 | Data bit sampled at the qualified rising SCK edge |
| out_upd | output | 1 | One-cycle strobe: present the next output bit |
| out_en | output | 1 | Tri-state enable for the serial data output |
| paused | output | 1 | Transfer is currently frozen |
| bit_pos | output | $clog2(WORD_BITS) | Bit position within the current word |

## Verification
On every cycle, the assertions check that no shift strobe appears while paused, that the output enable is off whenever paused, that the shift and update strobes never coincide, that the bit position stays constant across paused cycles, and that a rise of the synchronized chip select clears the pause and the counter. The level-dependent rules cannot be expressed as single-cycle properties, so only the bench scenarios show them. These are: the deferred entry on the next falling edge, the ignored release while SCK is high, the cancelled deferral, and resumption at the preserved bit. A behavioural model is compared with every output on every clock while these sequences are driven.

// File: rtl/spi_pause_pkg.sv
package spi_pause_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PEND = 2'd1,
    ST_HOLD = 2'd2
  } pause_st_t;
endpackage

// File: rtl/spi_pause_sync.sv
module spi_pause_sync #(
  parameter int               WIDTH   = 4,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= {STAGES{RST_VAL}};
    else     stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_pause_edge.sv
module spi_pause_edge #(
  parameter int               WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= lvl;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_det
    assign rise[i] =  lvl[i] & ~prev[i];
    assign fall[i] = ~lvl[i] &  prev[i];
  end
endmodule

// File: rtl/spi_pause_fsm.sv
module spi_pause_fsm
  import spi_pause_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sel,
  input  logic      sck_lvl,
  input  logic      sck_fall,
  input  logic      hold_lvl,
  input  logic      hold_rise,
  output pause_st_t st_q,
  output pause_st_t st_nx
);
  always_comb begin
    st_nx = st_q;
    if (!sel) begin
      st_nx = ST_RUN;
    end else begin
      unique case (st_q)
        ST_RUN:  if (!hold_lvl) st_nx = sck_lvl ? ST_PEND : ST_HOLD;
        ST_PEND: if (hold_lvl) st_nx = ST_RUN;
                 else if (sck_fall) st_nx = ST_HOLD;
        ST_HOLD: if (hold_rise && !sck_lvl) st_nx = ST_RUN;
        default: st_nx = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_RUN;
    else     st_q <= st_nx;
  end
endmodule

// File: rtl/spi_pause_bitcnt.sv
module spi_pause_bitcnt #(
  parameter int  WORD_BITS = 8,
  localparam int CNT_W     = $clog2(WORD_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

  always_ff @(posedge clk) begin
    if (rst || clr)   cnt <= '0;
    else if (step)    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/spi_pause_ctrl.sv
module spi_pause_ctrl
  import spi_pause_pkg::*;
#(
  parameter int  WORD_BITS   = 8,
  parameter int  SYNC_STAGES = 2,
  localparam int CNT_W       = $clog2(WORD_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sck_pin,
  input  logic             cs_n_pin,
  input  logic             hold_n_pin,
  input  logic             si_pin,
  output logic             shift_en,
  output logic             shift_bit,
  output logic             out_upd,
  output logic             out_en,
  output logic             paused,
  output logic [CNT_W-1:0] bit_pos
);
  // synchronized pin vector: {si, hold_n, cs_n, sck}
  logic [3:0] pins_s;
  logic       sck_s, cs_s, hold_s, si_s;
  logic [1:0] rise, fall;
  logic       sck_rise, sck_fall, hold_rise;
  logic       sel, shift_go;
  pause_st_t  st_q, st_nx;

  spi_pause_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0110)) u_sync (
    .clk(clk), .rst(rst),
    .d({si_pin, hold_n_pin, cs_n_pin, sck_pin}),
    .q(pins_s)
  );

  assign sck_s  = pins_s[0];
  assign cs_s   = pins_s[1];
  assign hold_s = pins_s[2];
  assign si_s   = pins_s[3];
  assign sel    = ~cs_s;

  spi_pause_edge #(.WIDTH(2), .RST_VAL(2'b10)) u_edge (
    .clk(clk), .rst(rst),
    .lvl({hold_s, sck_s}),
    .rise(rise), .fall(fall)
  );

  assign sck_rise  = rise[0];
  assign sck_fall  = fall[0];
  assign hold_rise = rise[1];

  spi_pause_fsm u_fsm (
    .clk(clk), .rst(rst), .sel(sel),
    .sck_lvl(sck_s), .sck_fall(sck_fall),
    .hold_lvl(hold_s), .hold_rise(hold_rise),
    .st_q(st_q), .st_nx(st_nx)
  );

  assign shift_go = sel & sck_rise & (st_q != ST_HOLD);

  spi_pause_bitcnt #(.WORD_BITS(WORD_BITS)) u_cnt (
    .clk(clk), .rst(rst), .clr(~sel), .step(shift_go), .cnt(bit_pos)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_en  <= 1'b0;
      shift_bit <= 1'b0;
      out_upd   <= 1'b0;
      out_en    <= 1'b0;
    end else begin
      shift_en <= shift_go;
      if (shift_go) shift_bit <= si_s;
      out_upd  <= sel & sck_fall & hold_s & (st_q == ST_RUN);
      out_en   <= sel & hold_s & (st_nx != ST_HOLD);
    end
  end

  assign paused = (st_q == ST_HOLD);
endmodule

// File: rtl/spi_pause_ctrl_chk.sv
module spi_pause_ctrl_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             paused,
  input logic             shift_en,
  input logic             out_upd,
  input logic             out_en,
  input logic [CNT_W-1:0] bit_pos,
  input logic             cs_sync
);
  // R7: no shift strobe while frozen
  a_r7_no_shift_paused: assert property (@(posedge clk) disable iff (rst)
    paused |-> !shift_en);

  // R4: driver enable off while frozen
  a_r4_oe_off_paused: assert property (@(posedge clk) disable iff (rst)
    paused |-> !out_en);

  // R2 / R3: shift and update strobes come from opposite SCK edges
  a_r3_upd_shift_excl: assert property (@(posedge clk) disable iff (rst)
    !(shift_en && out_upd));

  // R7: bit position frozen across consecutive paused cycles
  a_r7_cnt_hold: assert property (@(posedge clk) disable iff (rst)
    (paused && $past(paused)) |-> $stable(bit_pos));

  // R9: deselect clears pause and position
  a_r9_cs_clears: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_sync) |=> (!paused && bit_pos == '0));
endmodule

bind spi_pause_ctrl spi_pause_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .paused(paused), .shift_en(shift_en),
  .out_upd(out_upd), .out_en(out_en), .bit_pos(bit_pos), .cs_sync(cs_s)
);

// File: tb/spi_pause_ctrl_test.sv
`timescale 1ns/1ps
module spi_pause_ctrl_test;
  localparam int WB = 8;
  localparam int CW = $clog2(WB);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, si = 1'b0;
  logic shift_en, shift_bit, out_upd, out_en, paused;
  logic [CW-1:0] bit_pos;

  int n_cmp = 0, n_bad = 0;
  int upd_cnt = 0, shf_cnt = 0;
  logic [7:0] cap = '0;

  always #4 clk = ~clk;

  spi_pause_ctrl #(.WORD_BITS(WB)) uut (
    .clk(clk), .rst(rst), .sck_pin(sck), .cs_n_pin(cs_n), .hold_n_pin(hold_n),
    .si_pin(si), .shift_en(shift_en), .shift_bit(shift_bit), .out_upd(out_upd),
    .out_en(out_en), .paused(paused), .bit_pos(bit_pos)
  );

  // behavioural reference: pin history, state 0=run 1=deferred 2=paused
  logic h_sck[3], h_cs[3], h_hold[3], h_si[3];
  int   mst = 0, mcnt = 0;
  logic m_shift = 0, m_bit = 0, m_upd = 0, m_oe = 0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) begin
        h_sck[i] = 0; h_cs[i] = 1; h_hold[i] = 1; h_si[i] = 0;
      end
      mst = 0; mcnt = 0; m_shift = 0; m_bit = 0; m_upd = 0; m_oe = 0;
    end else begin
      bit s_sel, s_rise, s_fall, s_hrise;
      int ns;
      s_sel   = !h_cs[1];
      s_rise  = h_sck[1] && !h_sck[2];
      s_fall  = !h_sck[1] && h_sck[2];
      s_hrise = h_hold[1] && !h_hold[2];
      m_shift = s_sel && s_rise && (mst != 2);
      if (m_shift) m_bit = h_si[1];
      m_upd = s_sel && s_fall && h_hold[1] && (mst == 0);
      ns = mst;
      if (!s_sel) ns = 0;
      else if (mst == 0 && !h_hold[1]) ns = h_sck[1] ? 1 : 2;
      else if (mst == 1) begin
        if (h_hold[1]) ns = 0;
        else if (s_fall) ns = 2;
      end else if (mst == 2 && s_hrise && !h_sck[1]) ns = 0;
      if (!s_sel) mcnt = 0;
      else if (m_shift) mcnt = (mcnt + 1) % WB;
      m_oe = s_sel && h_hold[1] && (ns != 2);
      mst = ns;
      h_sck[2] = h_sck[1]; h_sck[1] = h_sck[0]; h_sck[0] = sck;
      h_cs[2]  = h_cs[1];  h_cs[1]  = h_cs[0];  h_cs[0]  = cs_n;
      h_hold[2] = h_hold[1]; h_hold[1] = h_hold[0]; h_hold[0] = hold_n;
      h_si[2]  = h_si[1];  h_si[1]  = h_si[0];  h_si[0]  = si;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison and monitors
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 shift_en", shift_en, m_shift);
      chk("R2 shift_bit", shift_bit, m_bit);
      chk("R2 bit_pos", bit_pos, mcnt);
      chk("R3 out_upd", out_upd, m_upd);
      chk("R4 out_en", out_en, m_oe);
      chk("R5 paused", paused, mst == 2);
      if (shift_en) begin cap = {cap[6:0], shift_bit}; shf_cnt++; end
      if (out_upd) upd_cnt++;
    end
  end

  task automatic wt(int n = 6);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    si = b; wt(); sck = 1'b1; wt(); sck = 1'b0; wt();
  endtask

  initial begin
    wt(4); rst = 1'b0; wt(2);
    chk("R1 out_en", out_en, 0);
    chk("R1 paused", paused, 0);
    chk("R1 bit_pos", bit_pos, 0);
    chk("R1 shift_en", shift_en, 0);

    // R2/R3: plain byte
    cs_n = 1'b0; wt(); cap = '0; upd_cnt = 0;
    for (int i = 7; i >= 0; i--) send_bit(8'hA5 >> i);
    chk("R2 byte", cap, 8'hA5);
    chk("R2 wrap", bit_pos, 0);
    chk("R3 upd count", upd_cnt, 8);

    // R5/R7/R8: immediate pause, ignored clocks, resume
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    hold_n = 1'b0; wt();
    chk("R5 paused", paused, 1);
    chk("R4 oe off", out_en, 0);
    shf_cnt = 0;
    for (int i = 0; i < 4; i++) send_bit(i[0]);
    chk("R7 pos kept", bit_pos, 3);
    chk("R7 no shifts", shf_cnt, 0);
    hold_n = 1'b1; wt();
    chk("R8 resumed", paused, 0);
    chk("R8 oe on", out_en, 1);
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    chk("R7 word done", bit_pos, 0);

    // R6/R4: deferred pause
    send_bit(1'b1); send_bit(1'b0);
    upd_cnt = 0;
    sck = 1'b1; wt();
    hold_n = 1'b0; wt();
    chk("R4 oe off deferred", out_en, 0);
    chk("R6 not yet", paused, 0);
    sck = 1'b0; wt();
    chk("R6 entered", paused, 1);
    chk("R6 no upd", upd_cnt, 0);

    // R8: release while SCK high is ignored
    sck = 1'b1; wt(); hold_n = 1'b1; wt(); sck = 1'b0; wt();
    chk("R8 still paused", paused, 1);
    hold_n = 1'b0; wt(); hold_n = 1'b1; wt();
    chk("R8 resume", paused, 0);
    chk("R8 pos", bit_pos, 3);

    // R10: cancelled deferral
    sck = 1'b1; wt(); hold_n = 1'b0; wt(); hold_n = 1'b1; wt(); sck = 1'b0; wt();
    chk("R10 cancel", paused, 0);
    chk("R10 pos", bit_pos, 4);

    // R9: deselect clears
    hold_n = 1'b0; wt();
    chk("R9 pre paused", paused, 1);
    cs_n = 1'b1; wt();
    chk("R9 paused clr", paused, 0);
    chk("R9 pos clr", bit_pos, 0);
    chk("R9 oe off", out_en, 0);
    hold_n = 1'b1; wt(); cs_n = 1'b0; wt();
    chk("R9 fresh", paused, 0);
    chk("R9 oe on", out_en, 1);
    cs_n = 1'b1; wt();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule